// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write port and read port run on independent clocks. Words are `DW` bits wide (9 by default) and the storage holds `2**AW` words. A write needs two active-low write enables. A read needs two active-low read enables. Four active-low status flags report the fill level: empty, full, almost-empty and almost-full. The full flag and the almost-full flag belong to the write clock. The empty flag and the almost-empty flag belong to the read clock.

The two thresholds come from two offset registers. The almost-empty offset is `n` and the almost-full offset is `m`, and both start at 7 after reset. If the second write enable is held low while reset is asserted, the block enters load mode and that pin becomes a load strobe for the offset registers. Each load goes to the empty offset and to the full offset in turn, and loading never stores a word in the buffer. The pointers cross between the two clock domains as Gray code through two-stage synchronisers.

Top module: `dcfifo_progflag`

## Requirements
- R1: While `rst_n` is low the pointers clear, `empty_n` and `almost_empty_n` are 0, `full_n` and `almost_full_n` are 1, and both offsets return to 7.
- R2: Words are read out in the order they were written. `rd_data` is registered and takes the next word on the read-clock edge that accepts the read.
- R3: `full_n` is 0 exactly when the settled count equals the depth. While `full_n` is 0, no write is stored, whatever the enables are.
- R4: `empty_n` is 0 exactly when the settled count is 0. While `empty_n` is 0, no read takes place and `rd_data` holds its value, whatever the enables are.
- R5: `almost_empty_n` is 0 when the settled count is at most `n`, and 1 otherwise.
- R6: `almost_full_n` is 0 when the settled count is at least depth − `m`, and 1 otherwise.
- R7: With the default offsets, every count from 8 up to depth − 8 leaves all four flags at 1.
- R8: In normal mode a write is stored only when both `wr_en1_n` and `wr_en2_ld_n` are 0. A read takes place only when both `rd_en1_n` and `rd_en2_n` are 0.
- R9: A 0 on `wr_en2_ld_n` while `rst_n` is low selects load mode. In load mode, `wr_en1_n` = 0 and `wr_en2_ld_n` = 0 on a write-clock edge copies `wr_data[AW:0]` into an offset register and stores nothing in the buffer. Successive loads go to `n`, then `m`, then `n` again, and so on. In load mode, `wr_en1_n` = 0 with `wr_en2_ld_n` = 1 is an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_clk | input | 1 | Write-side clock |
| wr_en1_n | input | 1 | First write enable, active low |
| wr_en2_ld_n | input | 1 | Second write enable, or the offset-load strobe in load mode |
| wr_data | input | DW | Word to write, or offset value to load |
| rd_clk | input | 1 | Read-side clock |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| rd_data | output | DW | Registered read word |
| empty_n | output | 1 | Empty flag, active low, read clock |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read clock |
| almost_full_n | output | 1 | Almost-full flag, active low, write clock |
| full_n | output | 1 | Full flag, active low, write clock |

## Verification
The assertions assume three things about the inputs. The write clock runs while reset is held, so that the mode can be captured. The offsets change only while the buffer is idle, because the read clock uses the empty offset without synchronising it. Each offset also stays no larger than the depth. The bench meets all three. It holds reset for several write-clock edges. It issues every offset load before it writes any data, using values between 2 and 5. Between operations it waits long enough for both synchroniser chains to settle, so the flags are compared against an exact count and never against a value in transit.

// File: rtl/dcfifo_progflag.sv
`timescale 1ns/1ps
module dcfifo_progflag #(
  parameter int DW      = 9,
  parameter int AW      = 6,
  parameter int DEF_OFS = 7
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en1_n,
  input  logic          wr_en2_ld_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          almost_empty_n,
  output logic          almost_full_n,
  output logic          full_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_C = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] OFS_RST = (AW+1)'(DEF_OFS);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, rg_s1, rg_s2, wbin_nxt, wcnt_nxt;
  logic [AW:0] rbin, rgray, wg_s1, wg_s2, rbin_nxt, rcnt_nxt;
  logic [AW:0] ofs_e, ofs_f;
  logic        ld_mode, ld_sel;

  wire wr_req = !wr_en1_n && (ld_mode ? wr_en2_ld_n : !wr_en2_ld_n);
  wire wr_acc = wr_req && full_n;
  wire ld_acc = ld_mode && !wr_en1_n && !wr_en2_ld_n;
  wire rd_acc = !rd_en1_n && !rd_en2_n && empty_n;

  assign wbin_nxt = wbin + (AW+1)'(wr_acc);
  assign wcnt_nxt = wbin_nxt - g2b(rg_s2);
  assign rbin_nxt = rbin + (AW+1)'(rd_acc);
  assign rcnt_nxt = g2b(wg_s2) - rbin_nxt;

  always_ff @(posedge wr_clk)
    if (!rst_n) ld_mode <= !wr_en2_ld_n;

  always_ff @(posedge wr_clk)
    if (wr_acc) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      full_n <= 1'b1; almost_full_n <= 1'b1;
      ofs_e <= OFS_RST; ofs_f <= OFS_RST; ld_sel <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      full_n        <= wcnt_nxt != DEPTH_C;
      almost_full_n <= wcnt_nxt < DEPTH_C - ofs_f;
      if (ld_acc) begin
        if (ld_sel) ofs_f <= wr_data[AW:0];
        else        ofs_e <= wr_data[AW:0];
        ld_sel <= !ld_sel;
      end
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      empty_n <= 1'b0; almost_empty_n <= 1'b0; rd_data <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      empty_n        <= rcnt_nxt != '0;
      almost_empty_n <= rcnt_nxt > ofs_e;
      if (rd_acc) rd_data <= mem[rbin[AW-1:0]];
    end
endmodule

// File: rtl/dcfifo_progflag_chk.sv
`timescale 1ns/1ps
module dcfifo_progflag_chk #(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input logic          rst_n,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_en1_n,
  input logic          wr_en2_ld_n,
  input logic          ld_mode,
  input logic [AW:0]   wbin,
  input logic [AW:0]   wgray,
  input logic [DW-1:0] rd_data,
  input logic          empty_n,
  input logic          almost_empty_n,
  input logic          almost_full_n,
  input logic          full_n
);
  p_full_blocks_write_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));

  p_empty_holds_data_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_data));

  p_empty_implies_aempty_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n);

  p_full_implies_afull_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !almost_full_n);

  p_load_no_store_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (ld_mode && !wr_en1_n && !wr_en2_ld_n) |=> $stable(wbin));

  p_gray_single_step_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
endmodule

bind dcfifo_progflag dcfifo_progflag_chk #(.DW(DW), .AW(AW)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk),
  .wr_en1_n(wr_en1_n), .wr_en2_ld_n(wr_en2_ld_n), .ld_mode(ld_mode),
  .wbin(wbin), .wgray(wgray), .rd_data(rd_data),
  .empty_n(empty_n), .almost_empty_n(almost_empty_n),
  .almost_full_n(almost_full_n), .full_n(full_n)
);

// File: tb/dcfifo_progflag_tb.sv
`timescale 1ns/1ps
module dcfifo_progflag_tb;
  localparam int DW = 9, AW = 4, D = 16;

  logic rst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en1_n = 1'b1, wr_en2_ld_n = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic empty_n, almost_empty_n, almost_full_n, full_n;
  int total = 0, failed = 0;

  dcfifo_progflag #(.DW(DW), .AW(AW)) u_dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en1_n(wr_en1_n), .wr_en2_ld_n(wr_en2_ld_n),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .rd_data(rd_data), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n), .full_n(full_n));

  always #4 wr_clk = ~wr_clk;
  initial begin #3; forever #4 rd_clk = ~rd_clk; end

  initial begin
    #(8 * 150000);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic flags(input string tag, input int cnt, input int n, input int m);
    chk(tag, {28'd0, empty_n, almost_empty_n, almost_full_n, full_n},
        {28'd0, cnt != 0, cnt > n, cnt < D - m, cnt != D});
  endtask

  task automatic wr(input logic [DW-1:0] d, input logic e1, input logic e2);
    @(negedge wr_clk);
    wr_data = d; wr_en1_n = e1; wr_en2_ld_n = e2;
    @(negedge wr_clk);
    wr_en1_n = 1'b1; wr_en2_ld_n = 1'b1;
    settle();
  endtask

  task automatic rd(input logic e1, input logic e2);
    @(negedge rd_clk);
    rd_en1_n = e1; rd_en2_n = e2;
    @(negedge rd_clk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
  endtask

  task automatic do_reset(input logic ld);
    @(negedge wr_clk);
    rst_n = 1'b0; wr_en2_ld_n = !ld;
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1; wr_en2_ld_n = 1'b1;
    settle();
  endtask

  function automatic logic [DW-1:0] pat(input int base, input int i);
    return DW'(base + i * 37);
  endfunction

  task automatic fill(input int n, input int m, input int base);
    for (int i = 0; i < D; i++) begin
      flags((i >= n + 1 && i <= D - m - 1) ? "R7 R5 R6" : "R3 R4 R5 R6", i, n, m);
      wr(pat(base, i), 1'b0, 1'b1 ^ ~u_ld(base));
    end
    flags("R3 R6 full", D, n, m);
  endtask

  function automatic logic u_ld(input int base);
    return base >= 100;
  endfunction

  task automatic drain(input int n, input int m, input int base);
    for (int i = 0; i < D; i++) begin
      rd(1'b0, 1'b0);
      chk("R2 order", {23'd0, rd_data}, {23'd0, pat(base, i)});
      settle();
      flags("R4 R5 R6 drain", D - 1 - i, n, m);
    end
  endtask

  initial begin
    do_reset(1'b0);
    flags("R1 reset", 0, 7, 7);
    chk("R1 rd_data reset", {23'd0, rd_data}, 32'd0);

    wr(9'h0AA, 1'b0, 1'b1);
    flags("R8 wen2 high blocks write", 0, 7, 7);
    wr(9'h0AB, 1'b1, 1'b0);
    flags("R8 wen1 high blocks write", 0, 7, 7);

    rd(1'b0, 1'b0);
    settle();
    chk("R4 read on empty keeps data", {23'd0, rd_data}, 32'd0);
    flags("R4 read on empty", 0, 7, 7);

    fill(7, 7, 5);
    wr(9'h1FF, 1'b0, 1'b0);
    flags("R3 write while full", D, 7, 7);

    rd(1'b0, 1'b1);
    rd(1'b1, 1'b0);
    settle();
    chk("R8 single read enable ignored", {23'd0, rd_data}, 32'd0);
    flags("R8 single read enable flags", D, 7, 7);

    drain(7, 7, 5);
    rd(1'b0, 1'b0);
    settle();
    chk("R3 R4 extra word not stored", {23'd0, rd_data}, {23'd0, pat(5, D - 1)});
    flags("R4 empty after drain", 0, 7, 7);

    do_reset(1'b1);
    flags("R1 reset load mode", 0, 7, 7);
    wr(9'd2, 1'b0, 1'b0);
    wr(9'd3, 1'b0, 1'b0);
    wr(9'd5, 1'b0, 1'b0);
    flags("R9 load stores no word", 0, 5, 3);
    fill(5, 3, 100);
    drain(5, 3, 100);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule